// File: doc/BRIEF.md
# Prioritised Interrupt Controller Register Bank

This block gathers 64 interrupt lines and keeps three state bits for each: enabled, pending and active. Each line also has a 4-bit priority. Software reaches all of it through a small 32-bit register bus. Enable and pending state are changed through paired registers: one address in each pair sets bits and the other clears them, and writing a 0 bit has no effect. A trigger register lets software make any line pending by writing its number.

A hardware line becomes pending when a rising edge is seen on its input. A line is eligible when it is enabled, pending and not active. Among the eligible lines, the block presents the one with the smallest priority value on a registered selection output, together with a valid flag.

The consumer uses two inputs to move a line through its states. Acknowledge moves the presented line from pending to active. Completion, which carries a line number, ends that line's active state.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all enable, pending and active bits and all priorities are 0, `sel_valid` is 0, and every register reads 0.
- R2: Writing a 1 to bit b of the word at 0x000 (lines 0-31) or 0x004 (lines 32-63) enables line 32*w+b, and a 0 bit changes nothing. Both the word at 0x000/0x004 and the word at 0x080/0x084 read back the enable state.
- R3: Writing a 1 to bit b of 0x080 or 0x084 disables the matching line, and a 0 bit changes nothing.
- R4: Writing a 1 to a bit of 0x100/0x104 makes that line pending, and writing a 1 to a bit of 0x180/0x184 removes its pending state. A 0 bit changes nothing. Both pairs read back the pending state.
- R5: The words at 0x200 and 0x204 read back the active state of lines 0-31 and 32-63.
- R6: The word at 0x300+4*g holds the priorities of lines 4g to 4g+3. Line 4g+k uses bits [8k+7:8k+4], and bits [8k+3:8k] read as 0. Priority 0 is the most urgent.
- R7: Writing to 0xE00 makes line wdata[8:0] pending. A value above 63 changes nothing. The word at 0xE00 reads as 0.
- R8: A 0-to-1 transition on `irq_in[i]` makes line i pending, including a high pulse one clock long. A level held high does not set the line pending again after software has cleared it.
- R9: `sel_valid` is 1 exactly when some line is eligible (enabled, pending and not active). `sel_id` is then the eligible line with the smallest priority value, with ties going to the lowest line number, and `sel_prio` is that line's priority.
- R10: The selection outputs are registered. They change at the same clock edge that updates the state that caused the change, and never before that edge.
- R11: When `ack` is high and `sel_valid` is 1 at a clock edge, line `sel_id` loses its pending state and becomes active. When `sel_valid` is 0, `ack` has no effect.
- R12: When `done` is high at a clock edge, line `done_id` stops being active.
- R13: If a rising edge on a line's hardware input arrives in the same cycle as an acknowledge or a clear-pending write for that line, the line stays pending.
- R14: Read data appears on `bus_rdata` in the cycle after `bus_re`, and is 0 in any other cycle. Unmapped addresses read 0, and reads change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_re` |
| irq_in | input | 64 | Hardware interrupt inputs, rising-edge sensitive |
| ack | input | 1 | Takes the presented line: pending to active |
| done | input | 1 | Ends the active state of `done_id` |
| done_id | input | 6 | Line number for `done` |
| sel_valid | output | 1 | An eligible line is presented |
| sel_id | output | 6 | Number of the presented line |
| sel_prio | output | 4 | Priority of the presented line |

## Verification
The most sensitive collision is a pending bit that is cleared and set in the same cycle. The clear comes from an acknowledge or a clear-pending write. The set comes from a rising edge on the same line's hardware input. The bench causes this by raising that line's input in the same cycle as the acknowledge, and again in the same cycle as the clear write. It then judges the outcome in two ways. Through the bus, it reads the pending and active words and expects both bits set. On the selection output, it expects the line to drop out while active and to return once completion is signalled.

// File: rtl/irqc_pkg.sv
// Shared constants for the interrupt controller register bank.
// The register region is taken from address bits [11:7].
// The word inside a region is taken from bits [6:2].
package irqc_pkg;
    localparam int unsigned ADDR_W    = 12;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned BANK_BITS = 32;  // lines per state word
    localparam int unsigned SLOT_BITS = 8;   // bits per priority slot
    localparam int unsigned SLOT_LSB  = 4;   // priority lives in upper nibble

    typedef enum logic [4:0] {
        RG_EN_SET = 5'h00,
        RG_EN_CLR = 5'h01,
        RG_PD_SET = 5'h02,
        RG_PD_CLR = 5'h03,
        RG_ACTIVE = 5'h04,
        RG_PRIO   = 5'h06,
        RG_TRIG   = 5'h1C
    } irqc_region_e;
endpackage

// File: rtl/irqc_edge.sv
// Rising-edge capture for the hardware interrupt inputs.
// Assumes irq_in is synchronous to clk.
// A line that is high for a single cycle produces one rise pulse.
module irqc_edge #(
    parameter int unsigned N = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq_in,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    // Hold last cycle's input levels.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= irq_in;
    end

    assign rise = irq_in & ~prev_q;
endmodule

// File: rtl/irqc_bus_dec.sv
// Bus decode for the register bank.
// It turns single-cycle writes into per-line set/clear masks and priority
// loads, and it registers the read data.
// Assumes N is a multiple of 32 and at most 128.
// bus_addr[1:0] are ignored.
module irqc_bus_dec
    import irqc_pkg::*;
#(
    parameter int unsigned N  = 64,
    parameter int unsigned PW = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    input  logic                  bus_we,
    input  logic                  bus_re,
    input  logic [N-1:0]          en_q,
    input  logic [N-1:0]          pd_q,
    input  logic [N-1:0]          act_q,
    input  logic [N-1:0][PW-1:0]  prio_q,
    output logic [N-1:0]          en_set,
    output logic [N-1:0]          en_clr,
    output logic [N-1:0]          pd_set,
    output logic [N-1:0]          pd_clr,
    output logic [N-1:0]          prio_we,
    output logic [N-1:0][PW-1:0]  prio_wdat,
    output logic [DATA_W-1:0]     bus_rdata
);
    localparam int unsigned NW  = N / BANK_BITS;
    localparam int unsigned NG  = N / 4;
    localparam int unsigned IDW = $clog2(N);

    logic [4:0]        region;
    logic [4:0]        widx;
    logic [8:0]        trig_id;
    logic [DATA_W-1:0] rd_word;
    logic              unused_lsb;

    assign region     = bus_addr[11:7];
    assign widx       = bus_addr[6:2];
    assign trig_id    = bus_wdata[8:0];
    assign unused_lsb = ^bus_addr[1:0];

    // Turn a write into set/clear masks and priority loads.
    always_comb begin : write_decode
        en_set    = '0;
        en_clr    = '0;
        pd_set    = '0;
        pd_clr    = '0;
        prio_we   = '0;
        prio_wdat = '0;
        if (bus_we) begin
            for (int w = 0; w < NW; w++) begin
                if (widx == 5'(w)) begin
                    case (region)
                        RG_EN_SET: en_set[w*BANK_BITS +: BANK_BITS] = bus_wdata;
                        RG_EN_CLR: en_clr[w*BANK_BITS +: BANK_BITS] = bus_wdata;
                        RG_PD_SET: pd_set[w*BANK_BITS +: BANK_BITS] = bus_wdata;
                        RG_PD_CLR: pd_clr[w*BANK_BITS +: BANK_BITS] = bus_wdata;
                        default: ;
                    endcase
                end
            end
            for (int g = 0; g < NG; g++) begin
                if (region == RG_PRIO && widx == 5'(g)) begin
                    for (int k = 0; k < 4; k++) begin
                        prio_we[4*g+k]   = 1'b1;
                        prio_wdat[4*g+k] = bus_wdata[SLOT_BITS*k+SLOT_LSB +: PW];
                    end
                end
            end
            if (region == RG_TRIG && widx == 5'd0 && trig_id < 9'(N))
                pd_set[trig_id[IDW-1:0]] = 1'b1;
        end
    end

    // Select the word addressed by a read.
    always_comb begin : read_mux
        rd_word = '0;
        for (int w = 0; w < NW; w++) begin
            if (widx == 5'(w)) begin
                case (region)
                    RG_EN_SET, RG_EN_CLR: rd_word = en_q[w*BANK_BITS +: BANK_BITS];
                    RG_PD_SET, RG_PD_CLR: rd_word = pd_q[w*BANK_BITS +: BANK_BITS];
                    RG_ACTIVE:            rd_word = act_q[w*BANK_BITS +: BANK_BITS];
                    default: ;
                endcase
            end
        end
        for (int g = 0; g < NG; g++) begin
            if (region == RG_PRIO && widx == 5'(g)) begin
                for (int k = 0; k < 4; k++)
                    rd_word[SLOT_BITS*k+SLOT_LSB +: PW] = prio_q[4*g+k];
            end
        end
    end

    // Register the read data; it is zero in cycles with no read.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_word;
        else             bus_rdata <= '0;
    end
endmodule

// File: rtl/irqc_state.sv
// Per-line enable, pending, active and priority storage.
// It exports both the current state and the next state, so the arbiter
// can judge the state that the coming edge will load.
// Set sources win over clear sources on the same bit.
module irqc_state #(
    parameter int unsigned N  = 64,
    parameter int unsigned PW = 4,
    localparam int unsigned IDW = $clog2(N)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         en_set,
    input  logic [N-1:0]         en_clr,
    input  logic [N-1:0]         pd_set,
    input  logic [N-1:0]         pd_clr,
    input  logic [N-1:0]         rise,
    input  logic [N-1:0]         prio_we,
    input  logic [N-1:0][PW-1:0] prio_wdat,
    input  logic                 ack_fire,
    input  logic [IDW-1:0]       ack_id,
    input  logic                 done,
    input  logic [IDW-1:0]       done_id,
    output logic [N-1:0]         en_q,
    output logic [N-1:0]         pd_q,
    output logic [N-1:0]         act_q,
    output logic [N-1:0][PW-1:0] prio_q,
    output logic [N-1:0]         en_n,
    output logic [N-1:0]         pd_n,
    output logic [N-1:0]         act_n,
    output logic [N-1:0][PW-1:0] prio_n
);
    logic [N-1:0] ack_mask;
    logic [N-1:0] done_mask;

    // Decode the acknowledge and completion line numbers.
    always_comb begin : id_decode
        ack_mask  = '0;
        done_mask = '0;
        for (int i = 0; i < N; i++) begin
            if (ack_fire && ack_id == IDW'(i)) ack_mask[i]  = 1'b1;
            if (done && done_id == IDW'(i))    done_mask[i] = 1'b1;
        end
    end

    // Form next state; sets are applied after clears.
    always_comb begin : next_state
        en_n  = (en_q & ~en_clr) | en_set;
        pd_n  = (pd_q & ~(pd_clr | ack_mask)) | pd_set | rise;
        act_n = (act_q & ~done_mask) | ack_mask;
        for (int i = 0; i < N; i++)
            prio_n[i] = prio_we[i] ? prio_wdat[i] : prio_q[i];
    end

    // Load the state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            pd_q   <= '0;
            act_q  <= '0;
            prio_q <= '0;
        end else begin
            en_q   <= en_n;
            pd_q   <= pd_n;
            act_q  <= act_n;
            prio_q <= prio_n;
        end
    end
endmodule

// File: rtl/irqc_arb_tree.sv
// Balanced comparison tree that finds the eligible line with the smallest
// priority value. On equal priority the lower line number wins.
// The tree is purely combinational.
// Assumes N is a power of two.
module irqc_arb_tree #(
    parameter int unsigned N  = 64,
    parameter int unsigned PW = 4,
    localparam int unsigned IDW = $clog2(N)
) (
    input  logic [N-1:0]         elig,
    input  logic [N-1:0][PW-1:0] prio,
    output logic                 win_valid,
    output logic [IDW-1:0]       win_id,
    output logic [PW-1:0]        win_prio
);
    for (genvar l = 0; l <= IDW; l++) begin : g_lvl
        localparam int unsigned CNT = N >> l;
        logic [CNT-1:0]          v;
        logic [CNT-1:0][PW-1:0]  p;
        logic [CNT-1:0][IDW-1:0] id;
        if (l == 0) begin : g_leaf
            for (genvar i = 0; i < CNT; i++) begin : g_i
                assign v[i]  = elig[i];
                assign p[i]  = prio[i];
                assign id[i] = IDW'(i);
            end
        end else begin : g_node
            for (genvar i = 0; i < CNT; i++) begin : g_i
                logic take_lo;
                // Lower-numbered half keeps the slot unless the upper half is strictly more urgent.
                assign take_lo = g_lvl[l-1].v[2*i] &&
                                 (!g_lvl[l-1].v[2*i+1] ||
                                  g_lvl[l-1].p[2*i] <= g_lvl[l-1].p[2*i+1]);
                assign v[i]  = g_lvl[l-1].v[2*i] | g_lvl[l-1].v[2*i+1];
                assign p[i]  = take_lo ? g_lvl[l-1].p[2*i]  : g_lvl[l-1].p[2*i+1];
                assign id[i] = take_lo ? g_lvl[l-1].id[2*i] : g_lvl[l-1].id[2*i+1];
            end
        end
    end

    assign win_valid = g_lvl[IDW].v[0];
    assign win_prio  = g_lvl[IDW].p[0];
    assign win_id    = g_lvl[IDW].id[0];
endmodule

// File: rtl/irq_prio_ctrl.sv
// Top of the prioritised interrupt controller register bank.
// It ties together the edge capture, the bus decode, the state registers and
// the comparison tree, and registers the selection outputs.
// The selection is computed from the next state, so it is never stale.
// Assumes NUM_IRQ is a power of two between 32 and 128.
// Assumes PRIO_W is at most 4.
module irq_prio_ctrl
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 64,
    parameter int unsigned PRIO_W  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    input  logic                       bus_we,
    input  logic                       bus_re,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic [NUM_IRQ-1:0]         irq_in,
    input  logic                       ack,
    input  logic                       done,
    input  logic [$clog2(NUM_IRQ)-1:0] done_id,
    output logic                       sel_valid,
    output logic [$clog2(NUM_IRQ)-1:0] sel_id,
    output logic [PRIO_W-1:0]          sel_prio
);
    localparam int unsigned IDW = $clog2(NUM_IRQ);

    logic [NUM_IRQ-1:0]             rise;
    logic [NUM_IRQ-1:0]             en_set, en_clr, pd_set, pd_clr, prio_we;
    logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_wdat;
    logic [NUM_IRQ-1:0]             en_q, pd_q, act_q;
    logic [NUM_IRQ-1:0]             en_n, pd_n, act_n;
    logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_q, prio_n;
    logic                           ack_fire;
    logic                           cand_valid;
    logic [IDW-1:0]                 cand_id;
    logic [PRIO_W-1:0]              cand_prio;

    assign ack_fire = ack & sel_valid;

    irqc_edge #(.N(NUM_IRQ)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq_in (irq_in),
        .rise   (rise)
    );

    irqc_bus_dec #(.N(NUM_IRQ), .PW(PRIO_W)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .en_q      (en_q),
        .pd_q      (pd_q),
        .act_q     (act_q),
        .prio_q    (prio_q),
        .en_set    (en_set),
        .en_clr    (en_clr),
        .pd_set    (pd_set),
        .pd_clr    (pd_clr),
        .prio_we   (prio_we),
        .prio_wdat (prio_wdat),
        .bus_rdata (bus_rdata)
    );

    irqc_state #(.N(NUM_IRQ), .PW(PRIO_W)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_set    (en_set),
        .en_clr    (en_clr),
        .pd_set    (pd_set),
        .pd_clr    (pd_clr),
        .rise      (rise),
        .prio_we   (prio_we),
        .prio_wdat (prio_wdat),
        .ack_fire  (ack_fire),
        .ack_id    (sel_id),
        .done      (done),
        .done_id   (done_id),
        .en_q      (en_q),
        .pd_q      (pd_q),
        .act_q     (act_q),
        .prio_q    (prio_q),
        .en_n      (en_n),
        .pd_n      (pd_n),
        .act_n     (act_n),
        .prio_n    (prio_n)
    );

    irqc_arb_tree #(.N(NUM_IRQ), .PW(PRIO_W)) u_arb (
        .elig      (en_n & pd_n & ~act_n),
        .prio      (prio_n),
        .win_valid (cand_valid),
        .win_id    (cand_id),
        .win_prio  (cand_prio)
    );

    // Register the selection alongside the state it describes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_valid <= 1'b0;
            sel_id    <= '0;
            sel_prio  <= '0;
        end else begin
            sel_valid <= cand_valid;
            sel_id    <= cand_id;
            sel_prio  <= cand_prio;
        end
    end
endmodule

// File: rtl/irqc_chk.sv
// Property checker for irq_prio_ctrl, attached by bind.
// It keeps its own record of input history and its own model of the best
// eligible line, separate from the design's logic.
module irqc_chk #(
    parameter int unsigned N  = 64,
    parameter int unsigned PW = 4,
    localparam int unsigned IDW = $clog2(N)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N-1:0]         irq_in,
    input logic                 ack,
    input logic                 done,
    input logic [IDW-1:0]       done_id,
    input logic                 sel_valid,
    input logic [IDW-1:0]       sel_id,
    input logic [PW-1:0]        sel_prio,
    input logic [N-1:0]         en_q,
    input logic [N-1:0]         pd_q,
    input logic [N-1:0]         act_q,
    input logic [N-1:0][PW-1:0] prio_q
);
    logic [N-1:0] prev_c;
    logic [N-1:0] rise_c;
    logic         better;

    // Track input levels for the checker's own edge view.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_c <= '0;
        else        prev_c <= irq_in;
    end
    assign rise_c = irq_in & ~prev_c;

    // Look for an eligible line that should have beaten the presented one.
    always_comb begin : best_model
        better = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (en_q[i] && pd_q[i] && !act_q[i] &&
                ((prio_q[i] < sel_prio) || (prio_q[i] == sel_prio && IDW'(i) < sel_id)))
                better = 1'b1;
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!sel_valid && en_q == '0 && pd_q == '0 && act_q == '0));

    // R9
    sel_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> (en_q[sel_id] && pd_q[sel_id] && !act_q[sel_id]));

    // R9
    none_missed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid |-> ((en_q & pd_q & ~act_q) == '0));

    // R9
    sel_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> (sel_prio == prio_q[sel_id]));

    // R9
    sel_best_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> !better);

    // R11
    ack_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && sel_valid) |=> act_q[$past(sel_id)]);

    // R12
    done_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(ack && sel_valid && sel_id == done_id)) |=> !act_q[$past(done_id)]);

    // R8
    rise_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise_c) |=> ((pd_q & $past(rise_c)) == $past(rise_c)));
endmodule

bind irq_prio_ctrl irqc_chk #(.N(NUM_IRQ), .PW(PRIO_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .ack       (ack),
    .done      (done),
    .done_id   (done_id),
    .sel_valid (sel_valid),
    .sel_id    (sel_id),
    .sel_prio  (sel_prio),
    .en_q      (en_q),
    .pd_q      (pd_q),
    .act_q     (act_q),
    .prio_q    (prio_q)
);

// File: tb/tb_irq_prio_ctrl.sv
// Scoreboard bench for irq_prio_ctrl.
// Read tasks queue the expected word, and a monitor compares bus_rdata when
// it appears.
// Selection checks are made at falling edges.
module tb_irq_prio_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic [63:0] irq_in = '0;
    logic        ack = 1'b0;
    logic        done = 1'b0;
    logic [5:0]  done_id = '0;
    logic        sel_valid;
    logic [5:0]  sel_id;
    logic [3:0]  sel_prio;

    int          n_tests = 0;
    int          n_fail  = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_mark = 1'b0;

    always #5 clk = ~clk;

    irq_prio_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .ack(ack), .done(done), .done_id(done_id), .sel_valid(sel_valid),
        .sel_id(sel_id), .sel_prio(sel_prio)
    );

    // Monitor: read data is due the cycle after a strobe.
    always @(posedge clk) rd_mark <= bus_re;
    always @(negedge clk) begin
        if (rd_mark) begin
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R14: unexpected read data %h expected none", bus_rdata);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s: rdata=%h expected %h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [11:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic check_sel(input logic v, input logic [5:0] id, input logic [3:0] p, input string t);
        n_tests++;
        if (sel_valid !== v || (v && (sel_id !== id || sel_prio !== p))) begin
            n_fail++;
            $display("FAIL %s: sel v/id/prio=%b/%0d/%0d expected %b/%0d/%0d",
                     t, sel_valid, sel_id, sel_prio, v, id, p);
        end
    endtask

    task automatic pulse_ack();
        ack = 1'b1; @(negedge clk); ack = 1'b0;
    endtask

    task automatic pulse_done(input logic [5:0] id);
        done = 1'b1; done_id = id; @(negedge clk); done = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run still going, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check_sel(1'b0, 6'd0, 4'd0, "R1 sel after reset");
        bus_read(12'h000, 32'h0, "R1 enable");
        bus_read(12'h104, 32'h0, "R1 pending");
        bus_read(12'h204, 32'h0, "R1 active");
        bus_read(12'h300, 32'h0, "R1 prio");
        // R2 set-enable
        bus_write(12'h000, 32'h0000_00F0);
        bus_write(12'h000, 32'h0);
        bus_read(12'h000, 32'h0000_00F0, "R2 set word");
        bus_read(12'h080, 32'h0000_00F0, "R2 clear word reads enable");
        bus_write(12'h004, 32'h8000_0001);
        bus_read(12'h004, 32'h8000_0001, "R2 upper word");
        // R3 clear-enable
        bus_write(12'h080, 32'h0000_0010);
        bus_read(12'h000, 32'h0000_00E0, "R3 clear line 4");
        bus_write(12'h084, 32'h0);
        bus_read(12'h084, 32'h8000_0001, "R3 zero write");
        // R6 priorities
        bus_write(12'h304, 32'hFFFF_FFFF);
        bus_read(12'h304, 32'hF0F0_F0F0, "R6 low nibbles zero");
        bus_write(12'h304, 32'h9030_30A0);
        bus_read(12'h304, 32'h9030_30A0, "R6 group 1");
        bus_write(12'h33C, 32'h1000_0000);
        bus_read(12'h33C, 32'h1000_0000, "R6 line 63");
        bus_write(12'h320, 32'h0000_0020);
        bus_read(12'h320, 32'h0000_0020, "R6 line 32");
        bus_read(12'h300, 32'h0, "R6 other group");
        check_sel(1'b0, 6'd0, 4'd0, "R9 nothing pending");
        // R10 no change before the edge, then R9 selection
        bus_addr = 12'h100; bus_wdata = 32'h0000_00C0; bus_we = 1'b1;
        #1 check_sel(1'b0, 6'd0, 4'd0, "R10 before edge");
        @(negedge clk); bus_we = 1'b0;
        check_sel(1'b1, 6'd6, 4'd3, "R10 after edge");
        bus_read(12'h100, 32'h0000_00C0, "R4 set-pend word");
        bus_read(12'h180, 32'h0000_00C0, "R4 clear-pend word");
        bus_write(12'h100, 32'h0000_0020);
        check_sel(1'b1, 6'd5, 4'd3, "R9 tie to lower line");
        bus_write(12'h100, 32'h0000_0010);
        check_sel(1'b1, 6'd5, 4'd3, "R9 disabled line ignored");
        bus_read(12'h100, 32'h0000_00F0, "R4 pending");
        bus_write(12'h104, 32'h8000_0000);
        check_sel(1'b1, 6'd63, 4'd1, "R9 more urgent line");
        bus_write(12'h184, 32'h8000_0000);
        check_sel(1'b1, 6'd5, 4'd3, "R4 clear pending");
        bus_read(12'h104, 32'h0, "R4 upper cleared");
        bus_write(12'h180, 32'h0);
        bus_read(12'h100, 32'h0000_00F0, "R4 zero clear write");
        // R11 acknowledge
        pulse_ack();
        check_sel(1'b1, 6'd6, 4'd3, "R11 next after ack");
        bus_read(12'h200, 32'h0000_0020, "R11 active");
        bus_read(12'h100, 32'h0000_00D0, "R11 pending cleared");
        pulse_ack();
        check_sel(1'b1, 6'd7, 4'd9, "R11 second ack");
        bus_read(12'h200, 32'h0000_0060, "R11 active two");
        // R12 completion
        pulse_done(6'd6);
        bus_read(12'h200, 32'h0000_0020, "R12 done 6");
        check_sel(1'b1, 6'd7, 4'd9, "R12 sel unchanged");
        pulse_done(6'd5);
        bus_read(12'h200, 32'h0, "R12 done 5");
        // R7 trigger by number
        bus_write(12'hE00, 32'd32);
        check_sel(1'b1, 6'd32, 4'd2, "R7 trigger 32");
        bus_write(12'hE00, 32'd64);
        bus_write(12'hE00, 32'h1FF);
        bus_read(12'h104, 32'h0000_0001, "R7 ids above 63 ignored");
        bus_read(12'h100, 32'h0000_0090, "R7 low word unchanged");
        bus_write(12'hE00, 32'd63);
        check_sel(1'b1, 6'd63, 4'd1, "R7 trigger 63");
        // R5 active upper word
        pulse_ack();
        bus_read(12'h204, 32'h8000_0000, "R5 line 63 active");
        pulse_done(6'd63);
        bus_read(12'h204, 32'h0, "R5 line 63 done");
        bus_write(12'h184, 32'hFFFF_FFFF);
        bus_write(12'h180, 32'hFFFF_FFFF);
        check_sel(1'b0, 6'd0, 4'd0, "R4 all cleared");
        // R8 hardware edges
        irq_in[7] = 1'b1; @(negedge clk); irq_in[7] = 1'b0;
        check_sel(1'b1, 6'd7, 4'd9, "R8 one-cycle pulse");
        bus_read(12'h100, 32'h0000_0080, "R8 pulse pending");
        irq_in[40] = 1'b1; @(negedge clk);
        bus_read(12'h104, 32'h0000_0100, "R8 level rise");
        bus_write(12'h184, 32'h0000_0100);
        repeat (2) @(negedge clk);
        bus_read(12'h104, 32'h0, "R8 held level no re-set");
        irq_in[40] = 1'b0;
        // R13 set wins over clear
        ack = 1'b1; irq_in[7] = 1'b1;
        @(negedge clk);
        ack = 1'b0; irq_in[7] = 1'b0;
        check_sel(1'b0, 6'd0, 4'd0, "R13 line active so not presented");
        bus_read(12'h100, 32'h0000_0080, "R13 pending kept over ack");
        bus_read(12'h200, 32'h0000_0080, "R13 active set");
        pulse_done(6'd7);
        check_sel(1'b1, 6'd7, 4'd9, "R13 returns after done");
        bus_addr = 12'h180; bus_wdata = 32'h0000_0080; bus_we = 1'b1; irq_in[7] = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; irq_in[7] = 1'b0;
        bus_read(12'h100, 32'h0000_0080, "R13 pending kept over clear write");
        // R11 ack ignored when nothing is presented
        bus_write(12'h180, 32'h0000_0080);
        check_sel(1'b0, 6'd0, 4'd0, "R11 none presented");
        pulse_ack();
        bus_read(12'h200, 32'h0, "R11 ignored ack active");
        bus_read(12'h100, 32'h0, "R11 ignored ack pending");
        // R14 read path
        bus_read(12'h400, 32'h0, "R14 unmapped");
        bus_read(12'hE00, 32'h0, "R14 trigger reads zero");
        bus_read(12'h000, 32'h0000_00E0, "R14 read has no side effect");
        @(negedge clk);
        n_tests++;
        if (bus_rdata !== 32'h0) begin
            n_fail++;
            $display("FAIL R14: idle rdata=%h expected 0", bus_rdata);
        end
        repeat (2) @(negedge clk);
        n_tests++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R14: %0d reads unanswered expected 0", exp_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule